// File: doc/BRIEF.md
# Inter-Pipeline Event Flag Unit

This unit keeps the event flags that three asynchronous pipelines in one core use to hand data to each other: a load pipe that fills the local buffer from global memory, a vector pipe that computes on the local buffer, and a store pipe that drains it back to global memory. Each pipe has one request port. In one cycle it can post a set (meaning "event ready for that peer") or a wait (meaning "do not go on until the peer has posted this event"). A flag is identified by the ordered triple of source pipe, destination pipe and event number.

Each flag is a small counter. A set may arrive long before its wait, for example to prime a buffer as free before a loop, and it is kept until a wait uses it. A wait whose flag is not pending raises that pipe's stall output and holds it. Only the pipe that waits is stalled. The stall clears once the set has been recorded. Two sticky error bits report sets lost to saturation and requests that name an illegal pipe pair.

Top module: `evf_unit`

## Requirements
- R1: Pipe codes are 0 = load, 1 = vector, 2 = store. Request fields are valid, op (0 = set, 1 = wait), peer (2 bits) and event (3 bits). For a set, peer is the destination. For a wait, peer is the source. A set marks its triple pending, and a later matching wait from the destination consumes it without stalling.
- R2: A wait on a triple with nothing pending raises the requesting pipe's stall in the request cycle and leaves every other pipe's stall alone. If the matching set is presented in cycle T, the stall is still high in T and is low in T+1.
- R3: Each flag counts up to 15. A set that finds the count at 15, with no consume in the same cycle, is dropped. err_overflow_o goes high from the next cycle and stays high until reset.
- R4: Each wait consumes exactly one set. After k sets on a triple, k waits complete without stall and the next one stalls.
- R5: A set and a new wait on the same triple in the same cycle, with nothing pending, cancel each other. The wait does not stall and nothing is left pending.
- R6: A peer equal to the requester's own code, or the code 3, is illegal. An illegal wait completes with no stall. An illegal set is dropped. Either one sets err_illegal_o from the next cycle, and it stays set until reset.
- R7: Flags are separate per ordered triple. A set does not satisfy a wait that differs from it in source, destination or event.
- R8: While a pipe has a wait outstanding, including the cycle in which its stall falls, any request it presents is ignored.
- R9: Reset clears all flags, outstanding waits, stalls and error bits.
- R10: A wait whose flag is already pending completes in the request cycle with stall low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld_i | input | 3 | Request valid, one bit per pipe |
| req_wait_i | input | 3 | Operation per pipe: 0 set, 1 wait |
| req_peer_i | input | 6 | Peer pipe code, 2 bits per pipe |
| req_ev_i | input | 9 | Event number, 3 bits per pipe |
| stall_o | output | 3 | Stall per pipe, high while its wait is unresolved |
| err_overflow_o | output | 1 | Sticky: a set was lost to saturation |
| err_illegal_o | output | 1 | Sticky: a request named an illegal peer |

## Verification
A counter that is off by one shows nothing at the ports until the wait for that triple arrives. The error appears as a stall that is missing or extra, possibly many cycles after the bad update. For this reason the stimulus always ends a sequence by draining the triple it used, and it looks at the stall in the exact cycle the requirement names. A parked wait that records the wrong triple shows up as a stall that never releases, or that releases on an unrelated set. The error bits are registered, so a wrong cause shows one cycle after the request.

// File: rtl/evf_pkg.sv
package evf_pkg;

    localparam int NPIPE  = 3;
    localparam int PIPE_W = 2;

    typedef enum logic [PIPE_W-1:0] {
        PIPE_LD   = 2'd0,
        PIPE_VEC  = 2'd1,
        PIPE_ST   = 2'd2,
        PIPE_NONE = 2'd3
    } pipe_e;

    // Flat position of the counter for (source, destination, event).
    function automatic int slot_of(input int src, input int dst, input int ev, input int nev);
        return (src * NPIPE + dst) * nev + ev;
    endfunction

endpackage

// File: rtl/evf_req_decode.sv
module evf_req_decode
    import evf_pkg::*;
#(
    parameter  int SELF   = 0,
    parameter  int NUM_EV = 8,
    localparam int EV_W   = $clog2(NUM_EV),
    localparam int NSLOT  = NPIPE * NPIPE * NUM_EV,
    localparam int SLOT_W = $clog2(NSLOT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic              op_wait_i,
    input  logic [PIPE_W-1:0] peer_i,
    input  logic [EV_W-1:0]   ev_i,
    input  logic              blocked_i,
    output logic [NSLOT-1:0]  set_hit_o,
    output logic              wait_new_o,
    output logic [PIPE_W-1:0] wait_src_o,
    output logic [EV_W-1:0]   wait_ev_o,
    output logic              illegal_o
);

    logic              legal;
    logic              accept;
    logic              set_go;
    logic [SLOT_W-1:0] set_idx;

    always_comb begin
        legal      = (peer_i != PIPE_NONE) && (int'(peer_i) != SELF);
        accept     = vld_i && !blocked_i;
        set_go     = accept && !op_wait_i && legal;
        wait_new_o = accept && op_wait_i && legal;
        illegal_o  = accept && !legal;
        wait_src_o = peer_i;
        wait_ev_o  = ev_i;
        set_idx    = SLOT_W'(slot_of(SELF, int'(peer_i), int'(ev_i), NUM_EV));
        set_hit_o  = set_go ? (NSLOT'(1) << set_idx) : '0;
    end

    // A blocked pipe must leave no trace on flags, waits or errors.
    p_blocked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_i |-> (set_hit_o == '0) && !wait_new_o && !illegal_o);

    // At most one counter is touched by one set.
    p_single_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(set_hit_o) <= 1);

endmodule

// File: rtl/evf_flag_cell.sv
module evf_flag_cell #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc_i,
    input  logic dec_i,
    output logic pending_o,
    output logic ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cell_t;

    cell_t cell_d, cell_q;

    always_comb begin
        cell_d = cell_q;
        ovf_o  = 1'b0;
        if (inc_i && !dec_i) begin
            if (cell_q.cnt == CNT_MAX) begin
                ovf_o = 1'b1;
            end else begin
                cell_d.cnt = cell_q.cnt + 1'b1;
            end
        end else if (dec_i && !inc_i && (cell_q.cnt != '0)) begin
            cell_d.cnt = cell_q.cnt - 1'b1;
        end
        pending_o = (cell_q.cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= '0;
        end else begin
            cell_q <= cell_d;
        end
    end

    // A consume is only issued against a pending flag or a same-cycle set.
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> (pending_o || inc_i));

    // A saturated flag stays saturated when a lone set arrives.
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q.cnt == CNT_MAX) && inc_i && !dec_i |=> (cell_q.cnt == CNT_MAX));

    // With no traffic the count is left alone.
    p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i && !dec_i |=> $stable(cell_q.cnt));

endmodule

// File: rtl/evf_waiter.sv
module evf_waiter
    import evf_pkg::*;
#(
    parameter  int SELF   = 0,
    parameter  int NUM_EV = 8,
    localparam int EV_W   = $clog2(NUM_EV),
    localparam int NSLOT  = NPIPE * NPIPE * NUM_EV,
    localparam int SLOT_W = $clog2(NSLOT) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_wait_i,
    input  logic [PIPE_W-1:0] new_src_i,
    input  logic [EV_W-1:0]   new_ev_i,
    input  logic [NSLOT-1:0]  pending_i,
    input  logic [NSLOT-1:0]  inc_i,
    output logic              stall_o,
    output logic [NSLOT-1:0]  dec_o,
    output logic              parked_o
);

    typedef struct packed {
        logic              parked;
        logic [PIPE_W-1:0] src;
        logic [EV_W-1:0]   ev;
    } wst_t;

    wst_t st_d, st_q;

    logic [PIPE_W-1:0] tgt_src;
    logic [EV_W-1:0]   tgt_ev;
    logic [SLOT_W-1:0] tgt_idx;
    logic              avail;
    logic              same;

    always_comb begin
        st_d    = st_q;
        dec_o   = '0;
        stall_o = 1'b0;
        tgt_src = st_q.parked ? st_q.src : new_src_i;
        tgt_ev  = st_q.parked ? st_q.ev  : new_ev_i;
        if (tgt_src == PIPE_NONE) begin
            tgt_src = '0;
        end
        tgt_idx = SLOT_W'(slot_of(int'(tgt_src), SELF, int'(tgt_ev), NUM_EV));
        avail   = pending_i[tgt_idx];
        same    = inc_i[tgt_idx];
        if (st_q.parked) begin
            if (avail) begin
                dec_o[tgt_idx] = 1'b1;
                st_d.parked    = 1'b0;
            end else begin
                stall_o = 1'b1;
            end
        end else if (new_wait_i) begin
            if (avail || same) begin
                dec_o[tgt_idx] = 1'b1;
            end else begin
                stall_o     = 1'b1;
                st_d.parked = 1'b1;
                st_d.src    = new_src_i;
                st_d.ev     = new_ev_i;
            end
        end
        parked_o = st_q.parked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A stalled cycle is always followed by an outstanding wait.
    p_stall_parks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> parked_o);

    // While parked and unresolved, the recorded triple does not move.
    p_park_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        parked_o && stall_o |=> parked_o && $stable(st_q.src) && $stable(st_q.ev));

    // A release cycle frees the pipe at the next edge.
    p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        parked_o && !stall_o |=> !parked_o);

endmodule

// File: rtl/evf_unit.sv
module evf_unit
    import evf_pkg::*;
#(
    parameter  int NUM_EV = 8,
    parameter  int CNT_W  = 4,
    localparam int EV_W   = $clog2(NUM_EV),
    localparam int NSLOT  = NPIPE * NPIPE * NUM_EV
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NPIPE-1:0]         req_vld_i,
    input  logic [NPIPE-1:0]         req_wait_i,
    input  logic [NPIPE*PIPE_W-1:0]  req_peer_i,
    input  logic [NPIPE*EV_W-1:0]    req_ev_i,
    output logic [NPIPE-1:0]         stall_o,
    output logic                     err_overflow_o,
    output logic                     err_illegal_o
);

    typedef struct packed {
        logic ovf;
        logic ill;
    } err_t;

    err_t err_d, err_q;

    logic [NSLOT-1:0]  set_hit [NPIPE];
    logic [NSLOT-1:0]  dec_v   [NPIPE];
    logic [NPIPE-1:0]  wait_new;
    logic [PIPE_W-1:0] wait_src [NPIPE];
    logic [EV_W-1:0]   wait_ev  [NPIPE];
    logic [NPIPE-1:0]  illegal;
    logic [NPIPE-1:0]  parked;
    logic [NSLOT-1:0]  inc_all;
    logic [NSLOT-1:0]  dec_all;
    logic [NSLOT-1:0]  pending;
    logic [NSLOT-1:0]  ovf_v;
    logic              ill_any;

    for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
        evf_req_decode #(
            .SELF   (p),
            .NUM_EV (NUM_EV)
        ) u_dec (
            .clk        (clk),
            .rst_n      (rst_n),
            .vld_i      (req_vld_i[p]),
            .op_wait_i  (req_wait_i[p]),
            .peer_i     (req_peer_i[p*PIPE_W +: PIPE_W]),
            .ev_i       (req_ev_i[p*EV_W +: EV_W]),
            .blocked_i  (parked[p]),
            .set_hit_o  (set_hit[p]),
            .wait_new_o (wait_new[p]),
            .wait_src_o (wait_src[p]),
            .wait_ev_o  (wait_ev[p]),
            .illegal_o  (illegal[p])
        );

        evf_waiter #(
            .SELF   (p),
            .NUM_EV (NUM_EV)
        ) u_wait (
            .clk        (clk),
            .rst_n      (rst_n),
            .new_wait_i (wait_new[p]),
            .new_src_i  (wait_src[p]),
            .new_ev_i   (wait_ev[p]),
            .pending_i  (pending),
            .inc_i      (inc_all),
            .stall_o    (stall_o[p]),
            .dec_o      (dec_v[p]),
            .parked_o   (parked[p])
        );
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_flag
        evf_flag_cell #(
            .CNT_W (CNT_W)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .inc_i     (inc_all[k]),
            .dec_i     (dec_all[k]),
            .pending_o (pending[k]),
            .ovf_o     (ovf_v[k])
        );
    end

    always_comb begin
        inc_all = '0;
        dec_all = '0;
        ill_any = 1'b0;
        for (int p = 0; p < NPIPE; p++) begin
            inc_all = inc_all | set_hit[p];
            dec_all = dec_all | dec_v[p];
            ill_any = ill_any | illegal[p];
        end
        err_d     = err_q;
        err_d.ovf = err_q.ovf | (|ovf_v);
        err_d.ill = err_q.ill | ill_any;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= '0;
        end else begin
            err_q <= err_d;
        end
    end

    assign err_overflow_o = err_q.ovf;
    assign err_illegal_o  = err_q.ill;

    // Error bits never clear on their own.
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow_o |=> err_overflow_o);

    p_ill_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_illegal_o |=> err_illegal_o);

    // The overflow bit rises only after a flag refused a set.
    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overflow_o) |-> $past(|ovf_v));

    // A pipe with an outstanding wait sees no new request accepted.
    p_no_double_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (parked & wait_new) == '0);

endmodule

// File: tb/tb_evf_unit.sv
`timescale 1ns/1ps
module tb_evf_unit;

    localparam int PL = 0;
    localparam int PV = 1;
    localparam int PS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req_vld_i = '0;
    logic [2:0] req_wait_i = '0;
    logic [5:0] req_peer_i = '0;
    logic [8:0] req_ev_i = '0;
    logic [2:0] stall_o;
    logic       err_overflow_o;
    logic       err_illegal_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evf_unit dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_vld_i      (req_vld_i),
        .req_wait_i     (req_wait_i),
        .req_peer_i     (req_peer_i),
        .req_ev_i       (req_ev_i),
        .stall_o        (stall_o),
        .err_overflow_o (err_overflow_o),
        .err_illegal_o  (err_illegal_o)
    );

    // Request encoding: {valid, op(1 = wait), peer[1:0], event[2:0]}
    function automatic logic [6:0] fs(input int peer, input int ev);
        return {1'b1, 1'b0, 2'(peer), 3'(ev)};
    endfunction
    function automatic logic [6:0] fw(input int peer, input int ev);
        return {1'b1, 1'b1, 2'(peer), 3'(ev)};
    endfunction
    localparam logic [6:0] NOP = 7'd0;

    // Row: {load req, vector req, store req, stall {S,V,L}, errors {ovf,ill}, requirement}
    function automatic logic [29:0] row(input logic [6:0] l, input logic [6:0] v,
                                        input logic [6:0] s, input logic [2:0] st,
                                        input logic [1:0] er, input int r);
        return {l, v, s, st, er, 4'(r)};
    endfunction

    localparam int NROW = 27;
    localparam logic [29:0] TBL [NROW] = '{
        row(fs(PV,0), NOP,      NOP,      3'b000, 2'b00, 1),  // R1 set L->V ev0
        row(NOP,      fw(PL,0), NOP,      3'b000, 2'b00, 10), // R10 pending wait
        row(NOP,      fw(PL,0), NOP,      3'b010, 2'b00, 2),  // R2 empty wait stalls V only
        row(fs(PV,0), NOP,      NOP,      3'b010, 2'b00, 2),  // R2 still high in set cycle
        row(NOP,      NOP,      NOP,      3'b000, 2'b00, 2),  // R2 released next cycle
        row(fs(PV,2), NOP,      fw(PL,2), 3'b100, 2'b00, 7),  // R7 other destination
        row(NOP,      fw(PL,3), NOP,      3'b110, 2'b00, 7),  // R7 other event
        row(fs(PS,2), NOP,      NOP,      3'b110, 2'b00, 2),
        row(NOP,      NOP,      NOP,      3'b010, 2'b00, 2),
        row(fs(PV,3), NOP,      NOP,      3'b010, 2'b00, 7),
        row(NOP,      NOP,      NOP,      3'b000, 2'b00, 2),
        row(NOP,      fw(PL,2), NOP,      3'b000, 2'b00, 1),  // R1 primed set kept
        row(fs(PV,5), fw(PL,5), NOP,      3'b000, 2'b00, 5),  // R5 same-cycle net
        row(NOP,      fw(PL,5), NOP,      3'b010, 2'b00, 5),  // R5 nothing left
        row(NOP,      NOP,      fs(PV,5), 3'b010, 2'b00, 7),  // R7 other source
        row(fs(PV,5), NOP,      NOP,      3'b010, 2'b00, 7),
        row(NOP,      NOP,      NOP,      3'b000, 2'b00, 2),
        row(NOP,      fw(PS,5), NOP,      3'b000, 2'b00, 7),
        row(NOP,      fw(PL,6), NOP,      3'b010, 2'b00, 8),
        row(fs(PV,6), fs(PS,0), NOP,      3'b010, 2'b00, 8),  // R8 V set ignored
        row(NOP,      NOP,      NOP,      3'b000, 2'b00, 8),
        row(NOP,      NOP,      fw(PV,0), 3'b100, 2'b00, 8),  // R8 proves set was lost
        row(NOP,      fs(PS,0), NOP,      3'b100, 2'b00, 8),
        row(NOP,      NOP,      NOP,      3'b000, 2'b00, 8),
        row(fw(PL,1), NOP,      NOP,      3'b000, 2'b00, 6),  // R6 self wait
        row(NOP,      fs(3,0),  NOP,      3'b000, 2'b01, 6),  // R6 code 3 set
        row(NOP,      NOP,      NOP,      3'b000, 2'b01, 6)
    };

    task automatic put(input int p, input logic [6:0] r);
        req_vld_i[p]        = r[6];
        req_wait_i[p]       = r[5];
        req_peer_i[p*2 +: 2] = r[4:3];
        req_ev_i[p*3 +: 3]   = r[2:0];
    endtask

    task automatic check(input string tag, input logic [2:0] es, input logic [1:0] ee);
        checks++;
        if (stall_o !== es || {err_overflow_o, err_illegal_o} !== ee) begin
            errors++;
            $display("FAIL %s: stall=%b err=%b expected stall=%b err=%b",
                     tag, stall_o, {err_overflow_o, err_illegal_o}, es, ee);
        end
    endtask

    // Drive at the falling edge, sample 5 ns later, well before the rising edge.
    task automatic step(input logic [6:0] l, input logic [6:0] v, input logic [6:0] s,
                        input string tag, input logic [2:0] es, input logic [1:0] ee);
        @(negedge clk);
        put(PL, l);
        put(PV, v);
        put(PS, s);
        #5;
        check(tag, es, ee);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        put(PL, NOP);
        put(PV, NOP);
        put(PS, NOP);
        @(negedge clk);
        rst_n = 1'b1;
        #5;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        check("R9 reset state", 3'b000, 2'b00);

        for (int i = 0; i < NROW; i++) begin
            step(TBL[i][29:23], TBL[i][22:16], TBL[i][15:9],
                 $sformatf("R%0d row %0d", TBL[i][3:0], i), TBL[i][8:6], TBL[i][5:4]);
        end

        // R3 / R4: sixteen sets on (L,S,4); the last is dropped.
        for (int i = 0; i < 16; i++) begin
            step(fs(PS,4), NOP, NOP, "R3 fill", 3'b000, 2'b01);
        end
        step(NOP, NOP, NOP, "R3 overflow flagged", 3'b000, 2'b11);
        for (int i = 0; i < 15; i++) begin
            step(NOP, NOP, fw(PL,4), "R4 consume one each", 3'b000, 2'b11);
        end
        step(NOP, NOP, fw(PL,4), "R3 sixteenth set dropped", 3'b100, 2'b11);
        step(fs(PS,4), NOP, NOP, "R2 hold until set", 3'b100, 2'b11);
        step(NOP, NOP, NOP, "R2 release", 3'b000, 2'b11);
        step(NOP, NOP, NOP, "R3 overflow sticky", 3'b000, 2'b11);

        // R9: reset discards a pending flag and the error bits.
        step(fs(PV,7), NOP, NOP, "R9 pre-reset set", 3'b000, 2'b11);
        do_reset();
        check("R9 cleared outputs", 3'b000, 2'b00);
        step(NOP, fw(PL,7), NOP, "R9 flag cleared", 3'b010, 2'b00);
        do_reset();
        check("R9 outstanding wait cleared", 3'b000, 2'b00);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule